// File: doc/BRIEF.md
# Programmable ROM/Flash Access Timer

This block runs read and write cycles on an external ROM or Flash device. A host request (read or write, single or burst) starts a transaction. The block drives an active-low chip select, output enable and write enable, and counts out the cycles each phase lasts. The cycle counts come from two timing fields, a 5-bit first-access count and a 4-bit next-access count. Each operation adds its own fixed offset to these fields, and one read offset also depends on the data-bus width.

The width of the bus is set by two strap pins. They are captured on the first clock edge after reset is released and do not change until the next reset. The decoded width is reported as a 2-bit status value. It changes the read timing: an 8-bit bus takes one cycle less on a single read or on the first burst beat. Address decode, byte assembly for narrow devices and DRAM control are handled elsewhere.

Top module: `flash_access_timer`

## Requirements
- R1: The strap pins are captured on the first rising clock edge after reset is released, and `bus_width_o` holds their decode until the next reset. The decode is: strap 00 gives 2'b00 (32-bit), strap 10 gives 2'b10 (64-bit), and any strap with bit 0 set gives 2'b01 (8-bit). Strap changes after the capture have no effect.
- R2: A single read (`req_wr_i`=0, `req_burst_i`=0) keeps `oe_n_o` low for `first_lat_i`+3 cycles on a 32-bit or 64-bit bus and for `first_lat_i`+2 cycles on an 8-bit bus. `rd_valid_o` and `done_o` are high together in the last of those cycles.
- R3: A burst read (`req_burst_i`=1) transfers exactly 4 beats. The first beat lasts as long as a single read; each later beat lasts `next_lat_i`+3 cycles. `rd_valid_o` pulses for one cycle at the end of every beat, and `done_o` is high with the fourth pulse.
- R4: A write (`req_wr_i`=1, burst flag ignored) holds `we_n_o` low for `first_lat_i`+2 cycles, starting in the first cycle of the transaction, whatever the bus width. `oe_n_o` stays high during a write.
- R5: After `we_n_o` rises, a write stays in recovery with `we_n_o` high and `cs_n_o` low for `next_lat_i`+4 cycles. `done_o` is high in the last recovery cycle. No `rd_valid_o` pulse occurs during a write.
- R6: `cs_n_o` is low for every cycle of a transaction and goes high in the cycle after `done_o`. It stays high for at least one cycle before the next transaction starts.
- R7: A request seen while a transaction is in progress, including in its `done_o` cycle, is ignored. It neither starts a new transaction nor changes the current one.
- R8: `first_lat_i` and `next_lat_i` are sampled on the clock edge that accepts the request. Changes to them later in the transaction do not change its timing.
- R9: While reset is asserted, `cs_n_o`, `oe_n_o` and `we_n_o` are high, `rd_valid_o` and `done_o` are low, and `bus_width_o` is 2'b00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| strap_i | input | 2 | Bus-width strap pins, captured after reset |
| req_i | input | 1 | Transaction request, accepted when idle |
| req_wr_i | input | 1 | 1 = write, 0 = read |
| req_burst_i | input | 1 | 1 = 4-beat burst read |
| first_lat_i | input | 5 | First-access / write-low count field |
| next_lat_i | input | 4 | Next-beat / write-recovery count field |
| cs_n_o | output | 1 | Chip select, active low |
| oe_n_o | output | 1 | Output enable, active low |
| we_n_o | output | 1 | Write enable, active low |
| rd_valid_o | output | 1 | One-cycle pulse at the end of each read beat |
| done_o | output | 1 | High in the last cycle of a transaction |
| bus_width_o | output | 2 | Decoded bus width status |

## Verification
The clock edge that accepts a request is counted as edge zero. The strobes change right after that edge, so cycle 1 of the transaction is the first sample taken at the following falling edge. The read-valid pulses and done are due in the last cycle of each counted phase, so a read beat ends at cycle N1, then at N1+M, and so on, and a write is done at cycle L+R. The bench drives inputs and samples outputs only on falling edges. It counts strobe-low cycles, and it records the cycle numbers of the pulses and of done, comparing them with values worked out from the field values and offsets. The width status is checked on the falling edge that follows the first rising edge after reset is released, and it is checked again after the straps have been changed.

// File: rtl/fat_pkg.sv
package fat_pkg;

  typedef enum logic [1:0] {
    BW_32 = 2'b00,
    BW_8  = 2'b01,
    BW_64 = 2'b10
  } bus_w_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_READ   = 2'b01,
    ST_WR_LOW = 2'b10,
    ST_WR_REC = 2'b11
  } seq_st_e;

  // Any strap with bit 0 set selects the narrow bus.
  function automatic bus_w_e decode_strap(input logic [1:0] s);
    if (s[0])      return BW_8;
    else if (s[1]) return BW_64;
    else           return BW_32;
  endfunction

endpackage

// File: rtl/fat_strap.sv
module fat_strap
  import fat_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] strap_i,
  output bus_w_e     width_o
);

  bus_w_e width_q, width_d;
  logic   cap_q, cap_d;

  always_comb begin
    width_d = width_q;
    cap_d   = cap_q;
    if (!cap_q) begin
      width_d = decode_strap(strap_i);
      cap_d   = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      width_q <= BW_32;
      cap_q   <= 1'b0;
    end else begin
      width_q <= width_d;
      cap_q   <= cap_d;
    end
  end

  assign width_o = width_q;

  // R1
  width_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_q |=> $stable(width_q));

endmodule

// File: rtl/fat_counter.sv
module fat_counter #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load_i)               cnt_d = load_val_i;
    else if (cnt_q != '0)     cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  // R2
  no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (zero_o && !load_i) |=> zero_o);

endmodule

// File: rtl/fat_seq.sv
module fat_seq
  import fat_pkg::*;
#(
  parameter int FA_W       = 5,
  parameter int NA_W       = 4,
  parameter int BEATS      = 4,
  parameter int RD_OFS_WD  = 3,
  parameter int RD_OFS_NR  = 2,
  parameter int NX_OFS     = 3,
  parameter int WL_OFS     = 2,
  parameter int WR_OFS     = 4,
  parameter int CNT_W      = FA_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_i,
  input  logic             wr_i,
  input  logic             burst_i,
  input  logic [FA_W-1:0]  first_i,
  input  logic [NA_W-1:0]  next_i,
  input  logic             narrow_i,
  input  logic             cnt_zero_i,
  output logic             cnt_load_o,
  output logic [CNT_W-1:0] cnt_val_o,
  output logic             cs_n_o,
  output logic             oe_n_o,
  output logic             we_n_o,
  output logic             rd_valid_o,
  output logic             done_o
);

  localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1;
  localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(BEATS - 1);

  seq_st_e           st_q, st_d;
  logic [BEAT_W-1:0] beat_q, beat_d;
  logic [NA_W-1:0]   nx_q, nx_d;
  logic              burst_q, burst_d;

  always_comb begin
    st_d       = st_q;
    beat_d     = beat_q;
    nx_d       = nx_q;
    burst_d    = burst_q;
    cnt_load_o = 1'b0;
    cnt_val_o  = '0;
    rd_valid_o = 1'b0;
    done_o     = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (req_i) begin
          cnt_load_o = 1'b1;
          nx_d       = next_i;
          burst_d    = burst_i;
          beat_d     = '0;
          if (wr_i) begin
            st_d      = ST_WR_LOW;
            cnt_val_o = CNT_W'(first_i) + CNT_W'(WL_OFS - 1);
          end else begin
            st_d      = ST_READ;
            cnt_val_o = CNT_W'(first_i) +
                        (narrow_i ? CNT_W'(RD_OFS_NR - 1) : CNT_W'(RD_OFS_WD - 1));
          end
        end
      end
      ST_READ: begin
        if (cnt_zero_i) begin
          rd_valid_o = 1'b1;
          if (!burst_q || beat_q == LAST_BEAT) begin
            done_o = 1'b1;
            st_d   = ST_IDLE;
          end else begin
            beat_d     = beat_q + 1'b1;
            cnt_load_o = 1'b1;
            cnt_val_o  = CNT_W'(nx_q) + CNT_W'(NX_OFS - 1);
          end
        end
      end
      ST_WR_LOW: begin
        if (cnt_zero_i) begin
          cnt_load_o = 1'b1;
          cnt_val_o  = CNT_W'(nx_q) + CNT_W'(WR_OFS - 1);
          st_d       = ST_WR_REC;
        end
      end
      ST_WR_REC: begin
        if (cnt_zero_i) begin
          done_o = 1'b1;
          st_d   = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      beat_q  <= '0;
      nx_q    <= '0;
      burst_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      beat_q  <= beat_d;
      nx_q    <= nx_d;
      burst_q <= burst_d;
    end
  end

  assign cs_n_o = (st_q == ST_IDLE);
  assign oe_n_o = (st_q != ST_READ);
  assign we_n_o = (st_q != ST_WR_LOW);

  // R6
  cs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> cs_n_o);

  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n_o |-> oe_n_o);

  // R3
  dv_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid_o |-> (!oe_n_o && !cs_n_o));

  // R7
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n_o && !done_o) |=> !cs_n_o);

  // R5
  rec_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(we_n_o) && !cs_n_o) |-> !done_o);

endmodule

// File: rtl/flash_access_timer.sv
module flash_access_timer
  import fat_pkg::*;
#(
  parameter int FA_W  = 5,
  parameter int NA_W  = 4,
  parameter int BEATS = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [1:0]      strap_i,
  input  logic            req_i,
  input  logic            req_wr_i,
  input  logic            req_burst_i,
  input  logic [FA_W-1:0] first_lat_i,
  input  logic [NA_W-1:0] next_lat_i,
  output logic            cs_n_o,
  output logic            oe_n_o,
  output logic            we_n_o,
  output logic            rd_valid_o,
  output logic            done_o,
  output logic [1:0]      bus_width_o
);

  localparam int CNT_W = FA_W + 1;

  bus_w_e           width;
  logic             cnt_load;
  logic [CNT_W-1:0] cnt_val;
  logic             cnt_zero;

  fat_strap u_strap (
    .clk     (clk),
    .rst_n   (rst_n),
    .strap_i (strap_i),
    .width_o (width)
  );

  fat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (cnt_load),
    .load_val_i (cnt_val),
    .zero_o     (cnt_zero)
  );

  fat_seq #(
    .FA_W  (FA_W),
    .NA_W  (NA_W),
    .BEATS (BEATS),
    .CNT_W (CNT_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .wr_i       (req_wr_i),
    .burst_i    (req_burst_i),
    .first_i    (first_lat_i),
    .next_i     (next_lat_i),
    .narrow_i   (width == BW_8),
    .cnt_zero_i (cnt_zero),
    .cnt_load_o (cnt_load),
    .cnt_val_o  (cnt_val),
    .cs_n_o     (cs_n_o),
    .oe_n_o     (oe_n_o),
    .we_n_o     (we_n_o),
    .rd_valid_o (rd_valid_o),
    .done_o     (done_o)
  );

  assign bus_width_o = width;

endmodule

// File: tb/flash_access_timer_tb.sv
module flash_access_timer_tb;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] strap = 2'b00;
  logic       req = 1'b0, req_wr = 1'b0, req_burst = 1'b0;
  logic [4:0] first_lat = 5'd0;
  logic [3:0] next_lat = 4'd0;
  logic       cs_n, oe_n, we_n, rd_valid, done;
  logic [1:0] bus_width;

  int total = 0;
  int bad   = 0;
  logic [1:0] cur_w = 2'b00;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_access_timer u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .strap_i     (strap),
    .req_i       (req),
    .req_wr_i    (req_wr),
    .req_burst_i (req_burst),
    .first_lat_i (first_lat),
    .next_lat_i  (next_lat),
    .cs_n_o      (cs_n),
    .oe_n_o      (oe_n),
    .we_n_o      (we_n),
    .rd_valid_o  (rd_valid),
    .done_o      (done),
    .bus_width_o (bus_width)
  );

  task automatic chk(input bit ok, input string rq, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
    end
  endtask

  // Reset with a given strap, check reset outputs (R9) and decode (R1)
  task automatic t_reset(input logic [1:0] s, input logic [1:0] expw);
    @(negedge clk);
    rst_n = 1'b0;
    strap = s;
    req   = 1'b0;
    repeat (2) @(negedge clk);
    chk(cs_n == 1'b1, "R9", "cs_n in reset", cs_n, 1);
    chk(oe_n == 1'b1 && we_n == 1'b1, "R9", "oe_n&we_n in reset", oe_n & we_n, 1);
    chk(rd_valid == 1'b0 && done == 1'b0, "R9", "valid|done in reset", rd_valid | done, 0);
    chk(bus_width == 2'b00, "R9", "width in reset", bus_width, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(bus_width == expw, "R1", "width decode", bus_width, expw);
    cur_w = expw;
    strap = ~s;
    repeat (2) @(negedge clk);
    chk(bus_width == expw, "R1", "width after strap change", bus_width, expw);
  endtask

  // Run one transaction; hold keeps requesting while busy (R7), poke
  // changes the fields after acceptance (R8).
  task automatic t_txn(input bit wr, input bit burst, input logic [4:0] f,
                       input logic [3:0] n, input bit hold, input bit poke,
                       input string rq);
    int n1, m, beats, exp_total, low, rec;
    int cs_cnt, oe_cnt, we_cnt, we_last, dv_cnt, done_at, cyc;
    int dv_at[4];
    n1    = int'(f) + ((cur_w == 2'b01) ? 2 : 3);
    m     = int'(n) + 3;
    beats = burst ? 4 : 1;
    low   = int'(f) + 2;
    rec   = int'(n) + 4;
    exp_total = wr ? (low + rec) : (n1 + (beats - 1) * m);
    cs_cnt = 0; oe_cnt = 0; we_cnt = 0; we_last = 0; dv_cnt = 0; done_at = 0;
    for (int i = 0; i < 4; i++) dv_at[i] = 0;

    @(negedge clk);
    req = 1'b1; req_wr = wr; req_burst = burst;
    first_lat = f; next_lat = n;
    cyc = 0;
    while (done_at == 0 && cyc < 300) begin
      @(negedge clk);
      cyc++;
      if (hold) req_wr = ~wr;
      else      req = 1'b0;
      if (poke) begin
        first_lat = ~f;
        next_lat  = ~n;
      end
      if (!cs_n) cs_cnt++;
      if (!oe_n) oe_cnt++;
      if (!we_n) begin we_cnt++; we_last = cyc; end
      if (rd_valid) begin
        if (dv_cnt < 4) dv_at[dv_cnt] = cyc;
        dv_cnt++;
      end
      if (done) begin
        done_at = cyc;
        req = 1'b0;
      end
    end
    chk(done_at == exp_total, rq, "done cycle", done_at, exp_total);
    chk(cs_cnt == exp_total, "R6", "cs_n low cycles", cs_cnt, exp_total);
    if (wr) begin
      chk(we_cnt == low, "R4", "we_n low cycles", we_cnt, low);
      chk(we_last == low, "R4", "we_n low from first cycle", we_last, low);
      chk(oe_cnt == 0, "R4", "oe_n low during write", oe_cnt, 0);
      chk(dv_cnt == 0, "R5", "valid pulses in write", dv_cnt, 0);
      chk(done_at - we_last == rec, "R5", "recovery cycles", done_at - we_last, rec);
    end else begin
      chk(oe_cnt == exp_total, "R2", "oe_n low cycles", oe_cnt, exp_total);
      chk(we_cnt == 0, "R2", "we_n low during read", we_cnt, 0);
      chk(dv_cnt == beats, "R3", "valid pulse count", dv_cnt, beats);
      for (int b = 0; b < beats && b < 4; b++)
        chk(dv_at[b] == n1 + b * m, rq, "valid pulse cycle", dv_at[b], n1 + b * m);
    end
    @(negedge clk);
    chk(cs_n == 1'b1, "R6", "cs_n high after done", cs_n, 1);
    chk(done == 1'b0 && oe_n == 1'b1 && we_n == 1'b1, "R7",
        "no new transaction after done", {done, oe_n, we_n}, 3'b011);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // 32-bit bus
    t_reset(2'b00, 2'b00);
    t_txn(1'b0, 1'b0, 5'd5,  4'd0,  1'b0, 1'b0, "R2");
    t_txn(1'b0, 1'b1, 5'd2,  4'd1,  1'b0, 1'b0, "R3");
    t_txn(1'b1, 1'b0, 5'd3,  4'd2,  1'b0, 1'b0, "R5");
    t_txn(1'b1, 1'b1, 5'd31, 4'd15, 1'b0, 1'b0, "R4");
    t_txn(1'b0, 1'b1, 5'd31, 4'd15, 1'b0, 1'b0, "R3");
    t_txn(1'b0, 1'b1, 5'd4,  4'd2,  1'b1, 1'b0, "R7");
    t_txn(1'b1, 1'b0, 5'd1,  4'd3,  1'b1, 1'b0, "R7");
    t_txn(1'b0, 1'b1, 5'd3,  4'd1,  1'b0, 1'b1, "R8");
    t_txn(1'b1, 1'b0, 5'd2,  4'd5,  1'b0, 1'b1, "R8");
    // 8-bit bus via both narrow strap codes
    t_reset(2'b11, 2'b01);
    t_txn(1'b0, 1'b0, 5'd4,  4'd0,  1'b0, 1'b0, "R2");
    t_txn(1'b0, 1'b1, 5'd0,  4'd0,  1'b0, 1'b0, "R3");
    t_txn(1'b1, 1'b0, 5'd0,  4'd0,  1'b0, 1'b0, "R4");
    t_reset(2'b01, 2'b01);
    t_txn(1'b0, 1'b0, 5'd31, 4'd0,  1'b0, 1'b0, "R2");
    // 64-bit bus
    t_reset(2'b10, 2'b10);
    t_txn(1'b0, 1'b0, 5'd1,  4'd0,  1'b0, 1'b0, "R2");
    t_txn(1'b0, 1'b1, 5'd0,  4'd0,  1'b0, 1'b0, "R3");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule